// File: doc/BRIEF.md
# Passive Two-Wire Bus Event Observer

This block listens to the clock and data lines of a two-wire serial bus and reports what it sees, without ever driving either line. Both lines are sampled on the system clock through a synchronizer. Edges found by comparing each sample with the one before are turned into bus conditions: START, repeated START, STOP, address and data bits, and the acknowledge bit that follows every byte.

Every decoded event leaves the block as a single-cycle strobe with a 4-bit event code and an 8-bit value. Bytes are tagged by bus phase (address or data) and by transfer direction. The direction comes from the low bit of the most recent address byte. A separate per-bit strobe, present when the bit-trace parameter is set, carries every sampled address or data bit so that a logger can rebuild the bit stream. It stands for event code 5, which never appears on the main event channel. The block suits on-chip bus logging, protocol debug capture and traffic counters.

Top module: `twi_bus_observer`

## Requirements
- R1: After reset the observer is waiting for a START, with evt_valid and bit_stb low. Reset treats both lines as high.
- R2: While waiting, a falling data line while the clock line is high produces event code 0 (START) with value 0, and address collection begins.
- R3: Bits are taken on each rising edge of the clock line, MSB first. On the eighth address bit the observer reports the byte shifted right by one. The code is 6 (address-read) when the low bit is 1 and 7 (address-write) when it is 0.
- R4: The clock rising edge after a complete byte is the acknowledge bit. It reports code 3 (ACK) with value 0 when the data line is 0, and code 4 (NACK) with value 0 when it is 1. Data collection follows in both cases.
- R5: Each full byte in the data phase reports its whole 8-bit value. The code is 8 (data-read) if the latched direction is read and 9 (data-write) if it is write.
- R6: During data collection, a rising data line while the clock line is high produces code 2 (STOP) with value 0 and a return to waiting. The same pattern during address collection is ignored, and the address byte then completes as if it had not occurred.
- R7: A START seen during data collection produces code 1 (repeated START) and discards any partial byte. Address collection restarts and the new address sets the direction for later data bytes.
- R8: A START pattern during address collection is ignored, and the byte keeps accumulating.
- R9: With the bit trace enabled, bit_stb pulses once for every address or data bit taken, with bit_val equal to the sampled data line. Acknowledge bits raise no bit strobe.
- R10: An event appears on evt_valid three rising clock edges after the line change that causes it. It lasts exactly one cycle.
- R11: After a STOP the repeated-START flag is cleared, so the next START is reported with code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| evt_valid | output | 1 | One-cycle event strobe |
| evt_code | output | 4 | Event code, valid with evt_valid |
| evt_byte | output | 8 | Shifted address or data byte; 0 for conditions and acknowledges |
| bit_stb | output | 1 | One-cycle strobe per sampled address/data bit |
| bit_val | output | 1 | Value of the sampled bit, valid with bit_stb |

## Verification
The bound checker checks several properties on every cycle. Every event must be caused by a detected condition one cycle earlier: a START or repeated START by a start pattern, a STOP by a stop pattern, and an acknowledge or bit strobe by a clock rising edge. It also checks that codes stay within the valid set and that conditions and acknowledges carry a zero value. Another check requires reported addresses to have a clear top bit. Byte assembly order, direction latching across bytes, and the patterns that are ignored in the wrong state can only be shown by the bench's whole transactions. The same holds for the cancelled partial byte on a repeated START and the three-edge latency.

// File: rtl/twi_obs_pkg.sv
package twi_obs_pkg;

  localparam int BYTE_W = 8;
  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    EV_START   = 4'd0,
    EV_RSTART  = 4'd1,
    EV_STOP    = 4'd2,
    EV_ACK     = 4'd3,
    EV_NACK    = 4'd4,
    EV_BIT     = 4'd5,
    EV_ADDR_RD = 4'd6,
    EV_ADDR_WR = 4'd7,
    EV_DATA_RD = 4'd8,
    EV_DATA_WR = 4'd9
  } twi_ev_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_ACK
  } twi_st_e;

  // Address byte: low bit set means a read transfer
  function automatic twi_ev_e f_addr_code(input logic rd_bit);
    return rd_bit ? EV_ADDR_RD : EV_ADDR_WR;
  endfunction

  function automatic twi_ev_e f_data_code(input logic dir_rd);
    return dir_rd ? EV_DATA_RD : EV_DATA_WR;
  endfunction

  function automatic twi_ev_e f_ack_code(input logic sda);
    return sda ? EV_NACK : EV_ACK;
  endfunction

  // Seven-bit address without the direction bit
  function automatic logic [BYTE_W-1:0] f_addr_value(input logic [BYTE_W-1:0] b);
    return {1'b0, b[BYTE_W-1:1]};
  endfunction

endpackage

// File: rtl/twi_obs_sync.sv
module twi_obs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= '1;
    else        pipe[0] <= d_in;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[i] <= '1;
      else        pipe[i] <= pipe[i-1];
    end
  end

  assign d_out = pipe[STAGES-1];

endmodule

// File: rtl/twi_obs_cond.sv
module twi_obs_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic start_seen,
  output logic stop_seen
);

  logic scl_prev;
  logic sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl;
      sda_prev <= sda;
    end
  end

  assign scl_rise   = !scl_prev && scl;
  assign start_seen = sda_prev && !sda && scl;
  assign stop_seen  = !sda_prev && sda && scl;

endmodule

// File: rtl/twi_obs_fsm.sv
module twi_obs_fsm
  import twi_obs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              start_seen,
  input  logic              stop_seen,
  input  logic              sda,
  output logic              evt_valid,
  output logic [CODE_W-1:0] evt_code,
  output logic [BYTE_W-1:0] evt_byte,
  output logic              bit_stb,
  output logic              bit_val
);

  localparam int CNT_W = $clog2(BYTE_W);

  twi_st_e            st_q, st_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [BYTE_W-1:0]  sh_q, sh_n;
  logic               dir_q, dir_n;
  logic               rep_q, rep_n;
  logic               ev_n;
  twi_ev_e            code_n;
  logic [BYTE_W-1:0]  byte_n;
  logic               bstb_n, bval_n;
  logic [BYTE_W-1:0]  byte_next;
  logic               last_bit;

  assign byte_next = {sh_q[BYTE_W-2:0], sda};
  assign last_bit  = (cnt_q == CNT_W'(BYTE_W-1));

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    dir_n  = dir_q;
    rep_n  = rep_q;
    ev_n   = 1'b0;
    code_n = EV_START;
    byte_n = '0;
    bstb_n = 1'b0;
    bval_n = bit_val;
    unique case (st_q)
      ST_IDLE: begin
        if (start_seen) begin
          ev_n   = 1'b1;
          code_n = rep_q ? EV_RSTART : EV_START;
          st_n   = ST_ADDR;
          cnt_n  = '0;
          sh_n   = '0;
          rep_n  = 1'b1;
          dir_n  = 1'b0;
        end
      end
      ST_ADDR, ST_DATA: begin
        if (scl_rise) begin
          bstb_n = 1'b1;
          bval_n = sda;
          if (last_bit) begin
            ev_n = 1'b1;
            if (st_q == ST_ADDR) begin
              code_n = f_addr_code(byte_next[0]);
              byte_n = f_addr_value(byte_next);
              dir_n  = byte_next[0];
            end else begin
              code_n = f_data_code(dir_q);
              byte_n = byte_next;
            end
            st_n  = ST_ACK;
            cnt_n = '0;
            sh_n  = '0;
          end else begin
            sh_n  = byte_next;
            cnt_n = cnt_q + CNT_W'(1);
          end
        end else if (st_q == ST_DATA && start_seen) begin
          ev_n   = 1'b1;
          code_n = rep_q ? EV_RSTART : EV_START;
          st_n   = ST_ADDR;
          cnt_n  = '0;
          sh_n   = '0;
          rep_n  = 1'b1;
          dir_n  = 1'b0;
        end else if (st_q == ST_DATA && stop_seen) begin
          ev_n   = 1'b1;
          code_n = EV_STOP;
          st_n   = ST_IDLE;
          cnt_n  = '0;
          sh_n   = '0;
          rep_n  = 1'b0;
          dir_n  = 1'b0;
        end
      end
      ST_ACK: begin
        if (scl_rise) begin
          ev_n   = 1'b1;
          code_n = f_ack_code(sda);
          st_n   = ST_DATA;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      dir_q     <= 1'b0;
      rep_q     <= 1'b0;
      evt_valid <= 1'b0;
      evt_code  <= '0;
      evt_byte  <= '0;
      bit_stb   <= 1'b0;
      bit_val   <= 1'b0;
    end else begin
      st_q      <= st_n;
      cnt_q     <= cnt_n;
      sh_q      <= sh_n;
      dir_q     <= dir_n;
      rep_q     <= rep_n;
      evt_valid <= ev_n;
      evt_code  <= ev_n ? code_n : evt_code;
      evt_byte  <= ev_n ? byte_n : evt_byte;
      bit_stb   <= bstb_n;
      bit_val   <= bval_n;
    end
  end

endmodule

// File: rtl/twi_bus_observer.sv
module twi_bus_observer
  import twi_obs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit BIT_TRACE   = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       evt_valid,
  output logic [3:0] evt_code,
  output logic [7:0] evt_byte,
  output logic       bit_stb,
  output logic       bit_val
);

  logic [1:0] lines_sync;
  logic       scl_s, sda_s;
  logic       cond_rise, cond_start, cond_stop;
  logic       fsm_bit_stb, fsm_bit_val;

  twi_obs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({scl_in, sda_in}),
    .d_out (lines_sync)
  );

  assign scl_s = lines_sync[1];
  assign sda_s = lines_sync[0];

  twi_obs_cond i_cond (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl        (scl_s),
    .sda        (sda_s),
    .scl_rise   (cond_rise),
    .start_seen (cond_start),
    .stop_seen  (cond_stop)
  );

  twi_obs_fsm i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_rise   (cond_rise),
    .start_seen (cond_start),
    .stop_seen  (cond_stop),
    .sda        (sda_s),
    .evt_valid  (evt_valid),
    .evt_code   (evt_code),
    .evt_byte   (evt_byte),
    .bit_stb    (fsm_bit_stb),
    .bit_val    (fsm_bit_val)
  );

  if (BIT_TRACE) begin : g_trace
    assign bit_stb = fsm_bit_stb;
    assign bit_val = fsm_bit_val;
  end else begin : g_no_trace
    assign bit_stb = 1'b0;
    assign bit_val = 1'b0;
  end

endmodule

// File: rtl/twi_obs_chk.sv
module twi_obs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       evt_valid,
  input logic [3:0] evt_code,
  input logic [7:0] evt_byte,
  input logic       bit_stb,
  input logic       rise_w,
  input logic       start_w,
  input logic       stop_w
);

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_code <= 4'd9 && evt_code != 4'd5)); // R3

  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_code <= 4'd1) |-> $past(start_w)); // R2

  AST_STOP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_code == 4'd2) |-> $past(stop_w)); // R6

  AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && (evt_code == 4'd3 || evt_code == 4'd4)) |-> $past(rise_w)); // R4

  AST_COND_ZERO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_code <= 4'd4) |-> evt_byte == 8'd0); // R4

  AST_ADDR_SHIFTED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && (evt_code == 4'd6 || evt_code == 4'd7)) |-> !evt_byte[7]); // R3

  AST_BIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> $past(rise_w)); // R9

  AST_BYTE_HAS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_code >= 4'd6) |-> $past(rise_w)); // R5

endmodule

bind twi_bus_observer twi_obs_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_valid (evt_valid),
  .evt_code  (evt_code),
  .evt_byte  (evt_byte),
  .bit_stb   (bit_stb),
  .rise_w    (cond_rise),
  .start_w   (cond_start),
  .stop_w    (cond_stop)
);

// File: tb/test_twi_bus_observer.sv
module test_twi_bus_observer;

  localparam int T = 4;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic       evt_valid;
  logic [3:0] evt_code;
  logic [7:0] evt_byte;
  logic       bit_stb;
  logic       bit_val;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  int   n_ev = 0;
  int   ev_code [64];
  int   ev_byte [64];
  int   n_bit = 0;
  logic bits [64];

  always #5 clk = ~clk;

  twi_bus_observer i_twi_bus_observer (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl),
    .sda_in    (sda),
    .evt_valid (evt_valid),
    .evt_code  (evt_code),
    .evt_byte  (evt_byte),
    .bit_stb   (bit_stb),
    .bit_val   (bit_val)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (evt_valid && n_ev < 64) begin
        ev_code[n_ev] = int'(evt_code);
        ev_byte[n_ev] = int'(evt_byte);
        n_ev++;
      end
      if (bit_stb && n_bit < 64) begin
        bits[n_bit] = bit_val;
        n_bit++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT && !done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below %0d", cyc, WD_LIMIT);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_log();
    wait_clk(2);
    n_ev = 0;
    n_bit = 0;
  endtask

  task automatic check_ev(input string tag, input int idx, input int code, input int val);
    chk({tag, " event present"}, int'(idx < n_ev), 1);
    if (idx < n_ev) begin
      chk({tag, " code"}, ev_code[idx], code);
      chk({tag, " value"}, ev_byte[idx], val);
    end
  endtask

  task automatic drive_bit(input logic b);
    scl = 1'b0; sda = b; wait_clk(T);
    scl = 1'b1;          wait_clk(T);
    scl = 1'b0;          wait_clk(T);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) drive_bit(v[i]);
  endtask

  task automatic bus_start();
    sda = 1'b1; scl = 1'b1; wait_clk(T);
    sda = 1'b0;             wait_clk(T);
    scl = 1'b0;             wait_clk(T);
  endtask

  task automatic bus_rstart();
    scl = 1'b0; sda = 1'b1; wait_clk(T);
    scl = 1'b1;             wait_clk(T);
    sda = 1'b0;             wait_clk(T);
    scl = 1'b0;             wait_clk(T);
  endtask

  task automatic bus_stop();
    scl = 1'b0; sda = 1'b0; wait_clk(T);
    scl = 1'b1;             wait_clk(T);
    sda = 1'b1;             wait_clk(T);
  endtask

  // R1: idle after reset
  task automatic t_reset();
    chk("R1 evt_valid after reset", int'(evt_valid), 0);
    chk("R1 bit_stb after reset", int'(bit_stb), 0);
    wait_clk(10);
    chk("R1 no events while idle", n_ev, 0);
  endtask

  // R2 R3 R4 R5 R6 R9: write transfer
  task automatic t_write();
    logic [7:0] a = 8'hA2;
    clear_log();
    bus_start();
    send_byte(a);
    drive_bit(1'b0);
    send_byte(8'h3C);
    drive_bit(1'b1);
    bus_stop();
    wait_clk(8);
    chk("R2 R3 R5 R6 write event count", n_ev, 6);
    check_ev("R2 start", 0, 0, 0);
    check_ev("R3 address-write", 1, 7, int'(a >> 1));
    check_ev("R4 ack", 2, 3, 0);
    check_ev("R5 data-write", 3, 9, 'h3C);
    check_ev("R4 nack", 4, 4, 0);
    check_ev("R6 stop", 5, 2, 0);
    chk("R9 bit count (8+8+stop clock)", n_bit, 17);
    for (int i = 0; i < 8; i++) chk("R9 address bit value", int'(bits[i]), int'(a[7-i]));
  endtask

  // R3 R5 R11: read transfer after a STOP
  task automatic t_read();
    clear_log();
    bus_start();
    send_byte(8'hA3);
    drive_bit(1'b0);
    send_byte(8'h5A);
    drive_bit(1'b1);
    bus_stop();
    wait_clk(8);
    chk("R11 read event count", n_ev, 6);
    check_ev("R11 plain start after stop", 0, 0, 0);
    check_ev("R3 address-read", 1, 6, 'h51);
    check_ev("R5 data-read", 3, 8, 'h5A);
    check_ev("R6 stop", 5, 2, 0);
  endtask

  // R7: repeated START cancels partial byte and re-latches direction
  task automatic t_rstart();
    clear_log();
    bus_start();
    send_byte(8'h40);
    drive_bit(1'b0);
    drive_bit(1'b1); drive_bit(1'b0); drive_bit(1'b1);
    bus_rstart();
    send_byte(8'h41);
    drive_bit(1'b0);
    send_byte(8'hFF);
    drive_bit(1'b1);
    bus_stop();
    wait_clk(8);
    chk("R7 event count", n_ev, 9);
    check_ev("R7 address-write", 1, 7, 'h20);
    check_ev("R7 repeated start", 3, 1, 0);
    check_ev("R7 address-read after rstart", 4, 6, 'h20);
    check_ev("R7 data-read uses new direction", 6, 8, 'hFF);
    check_ev("R7 stop", 8, 2, 0);
  endtask

  // R6: STOP pattern inside address byte is ignored
  task automatic t_stop_in_addr();
    clear_log();
    bus_start();
    drive_bit(1'b1); drive_bit(1'b1); drive_bit(1'b0);
    bus_stop();
    drive_bit(1'b1); drive_bit(1'b0); drive_bit(1'b0); drive_bit(1'b1);
    wait_clk(6);
    chk("R6 ignored stop leaves only start+address", n_ev, 2);
    check_ev("R6 address completes (0xC9)", 1, 6, 'h64);
    drive_bit(1'b0);
    bus_stop();
    wait_clk(8);
    check_ev("R6 real stop after ack", 3, 2, 0);
  endtask

  // R8: START pattern inside address byte is ignored
  task automatic t_start_in_addr();
    clear_log();
    bus_start();
    drive_bit(1'b1); drive_bit(1'b0);
    bus_rstart();
    drive_bit(1'b0); drive_bit(1'b0); drive_bit(1'b1); drive_bit(1'b1); drive_bit(1'b0);
    drive_bit(1'b0);
    bus_stop();
    wait_clk(8);
    chk("R8 event count", n_ev, 4);
    check_ev("R8 address keeps bits (0xA6)", 1, 7, 'h53);
    check_ev("R8 ack", 2, 3, 0);
  endtask

  // R10: latency and single-cycle strobe
  task automatic t_latency();
    clear_log();
    scl = 1'b1; sda = 1'b1; wait_clk(T);
    sda = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R10 no event after two edges", int'(evt_valid), 0);
    @(negedge clk);
    chk("R10 event after three edges", int'(evt_valid), 1);
    chk("R10 event is START", int'(evt_code), 0);
    @(negedge clk);
    chk("R10 strobe lasts one cycle", int'(evt_valid), 0);
    wait_clk(T);
    scl = 1'b0; wait_clk(T);
    send_byte(8'hA0);
    drive_bit(1'b0);
    bus_stop();
    wait_clk(8);
    check_ev("R10 cleanup stop", 3, 2, 0);
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    t_reset();
    t_write();
    t_read();
    t_rstart();
    t_stop_in_addr();
    t_start_in_addr();
    t_latency();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule